// File: doc/BRIEF.md
# Resolution-Selectable Tracking Angle Counter

This block keeps the digital angle inside a type II tracking converter loop. Every strobe from the loop's oscillator moves a 16-bit up/down counter by one count, up or down as the direction input says. The counter's upper 14 bits form the parallel angle word. A two-bit resolution code and a linear-transducer flag choose how many of those bits are kept, and every bit that is not kept reads 0.

The word passes through a holding register. That register follows the angle while the hold input is high and freezes while it is low. The bus is split into an upper group of 8 bits and a lower group of 6 bits. Each group has its own active-low enable and floats when disabled. A busy pulse of fixed length follows every counter step. If the hold is applied while that pulse is high, the register shows the word from before the step, so a reader never sees a word in the middle of an update.

Top module: `angle_track_counter`

## Requirements
- R1: Each clock with `step_i` high moves the 16-bit counter by one: up when `dir_up_i` is 1 and down when it is 0. It wraps modulo 65536 in both directions.
- R2: While `step_i` stays low, the counter, the latched word and `data_o` do not change.
- R3: In resolver mode (`lin_mode_i`=0) the word is counter bits [15:2] placed on `data_o[13:0]`. Code 00 keeps `data_o[13:4]` (10 bits), code 01 keeps `data_o[13:2]` (12 bits), and codes 10 and 11 keep all 14 bits. Dropped bits read 0.
- R4: In linear-transducer mode (`lin_mode_i`=1) the LSB position is the same as in resolver mode, and `data_o[13:12]` are forced to 0. Codes 00, 01 and 10/11 therefore give 8, 10 and 12 bits, and the 10-bit word has its LSB at `data_o[2]`.
- R5: With `hold_n_i` high the register is transparent. A step sampled at clock edge k appears on `data_o` after edge k+1.
- R6: While `hold_n_i` stays low, `data_o` stays frozen whatever steps arrive.
- R7: If `hold_n_i` goes low while `busy_o` is high, the register captures the word as it was before the step that started the pulse.
- R8: `data_o[13:6]` is driven only while `en_hi_n_i` is 0. Otherwise it is high impedance.
- R9: `data_o[5:0]` is driven only while `en_lo_n_i` is 0. Otherwise it is high impedance.
- R10: A step sampled at edge k raises `busy_o` after edge k. It stays high for exactly `BUSY_CYCLES` clocks, and another step restarts the full count.
- R11: After reset the counter is 0, `busy_o` is 0 and the latched word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Oscillator step strobe, one count per high clock |
| dir_up_i | input | 1 | Step direction, 1 = count up |
| res_code_i | input | 2 | Resolution select |
| lin_mode_i | input | 1 | 1 = linear-transducer word layout |
| hold_n_i | input | 1 | Active-low hold of the output register |
| en_hi_n_i | input | 1 | Active-low enable of `data_o[13:6]` |
| en_lo_n_i | input | 1 | Active-low enable of `data_o[5:0]` |
| data_o | output | 14 | Tri-state parallel angle word, natural binary |
| busy_o | output | 1 | Positive pulse after each counter update |

## Verification
The bench builds the block with `BUSY_CYCLES` = 4 and keeps the default widths. The short pulse lets the test reach the end of a pulse, a pulse restarted by a second step, and a hold applied while busy, all within a few clocks. The default 16-bit counter still gives the real wrap from 0 to 65535 in both directions and the real 14-bit word with both bus groups. Pull-ups on the bench's bus nets turn a floating group into a known all-ones value.

// File: rtl/angle_pkg.sv
package angle_pkg;

    typedef enum logic [1:0] {
        RES_NARROW = 2'b00,
        RES_MID    = 2'b01,
        RES_WIDE   = 2'b10,
        RES_FULL   = 2'b11
    } res_code_e;

    // number of word LSBs forced to zero for a resolution code
    function automatic int unsigned lsb_drop(res_code_e code, int unsigned step);
        case (code)
            RES_NARROW: return 2 * step;
            RES_MID:    return step;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/angle_updown_cnt.sv
module angle_updown_cnt #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             up_i,
    output logic [OUT_W-1:0] ang_o,
    output logic [OUT_W-1:0] snap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step_i) begin
            state_d.snap = state_q.cnt;
            state_d.cnt  = up_i ? state_q.cnt + CNT_W'(1) : state_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ang_o  = state_q.cnt[CNT_W-1 -: OUT_W];
    assign snap_o = state_q.snap[CNT_W-1 -: OUT_W];

    assert_count_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && up_i) |=> state_q.cnt == $past(state_q.cnt) + CNT_W'(1));
    assert_count_dn_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !up_i) |=> state_q.cnt == $past(state_q.cnt) - CNT_W'(1));
    assert_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q.cnt));

endmodule

// File: rtl/busy_pulse_gen.sv
module busy_pulse_gen #(
    parameter int unsigned BUSY_CYCLES = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic busy_o
);

    localparam int unsigned BUSY_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        logic [BUSY_W-1:0] left;
    } busy_state_t;

    busy_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step_i)                    state_d.left = BUSY_W'(BUSY_CYCLES);
        else if (state_q.left != '0)   state_d.left = state_q.left - BUSY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy_o = (state_q.left != '0);

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> busy_o);
    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && state_q.left == BUSY_W'(1)) |=> !busy_o);

endmodule

// File: rtl/angle_res_format.sv
module angle_res_format
    import angle_pkg::*;
#(
    parameter int unsigned OUT_W    = 14,
    parameter int unsigned RES_STEP = 2,
    parameter int unsigned LIN_DROP = 2
) (
    input  logic [OUT_W-1:0] ang_i,
    input  logic [1:0]       code_i,
    input  logic             lin_i,
    output logic [OUT_W-1:0] word_o
);

    int unsigned      drop;
    logic [OUT_W-1:0] keep;

    always_comb drop = lsb_drop(res_code_e'(code_i), RES_STEP);

    for (genvar i = 0; i < OUT_W; i++) begin : g_mask
        assign keep[i] = (i >= int'(drop)) && !(lin_i && (i >= int'(OUT_W - LIN_DROP)));
    end

    assign word_o = ang_i & keep;

    always_comb begin
        if (lin_i) begin
            assert_lin_top_zero_R4: assert (word_o[OUT_W-1 -: LIN_DROP] == '0);
        end
        if (code_i == 2'b00) begin
            assert_narrow_low_zero_R3: assert (word_o[2*RES_STEP-1:0] == '0);
        end
    end

endmodule

// File: rtl/angle_out_latch.sv
module angle_out_latch #(
    parameter int unsigned OUT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_n_i,
    input  logic             busy_i,
    input  logic [OUT_W-1:0] live_i,
    input  logic [OUT_W-1:0] snap_i,
    output logic [OUT_W-1:0] word_o
);

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             hold_prev_n;
    } latch_state_t;

    latch_state_t state_d, state_q;

    always_comb begin
        state_d             = state_q;
        state_d.hold_prev_n = hold_n_i;
        if (hold_n_i)                          state_d.word = live_i;
        else if (state_q.hold_prev_n && busy_i) state_d.word = snap_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.word        <= '0;
            state_q.hold_prev_n <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o = state_q.word;

    assert_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_n_i |=> word_o == $past(live_i));
    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n_i && !state_q.hold_prev_n) |=> $stable(word_o));
    assert_busy_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n_i && state_q.hold_prev_n && busy_i) |=> word_o == $past(snap_i));

endmodule

// File: rtl/angle_track_counter.sv
module angle_track_counter #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned OUT_W       = 14,
    parameter int unsigned HI_W        = 8,
    parameter int unsigned BUSY_CYCLES = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             dir_up_i,
    input  logic [1:0]       res_code_i,
    input  logic             lin_mode_i,
    input  logic             hold_n_i,
    input  logic             en_hi_n_i,
    input  logic             en_lo_n_i,
    output logic [OUT_W-1:0] data_o,
    output logic             busy_o
);

    localparam int unsigned LO_W = OUT_W - HI_W;

    logic [OUT_W-1:0] ang_w, snap_w, live_word, snap_word, latched;

    angle_updown_cnt #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .up_i(dir_up_i),
        .ang_o(ang_w), .snap_o(snap_w)
    );

    busy_pulse_gen #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .busy_o(busy_o)
    );

    angle_res_format #(.OUT_W(OUT_W)) u_fmt_live (
        .ang_i(ang_w), .code_i(res_code_i), .lin_i(lin_mode_i), .word_o(live_word)
    );

    angle_res_format #(.OUT_W(OUT_W)) u_fmt_snap (
        .ang_i(snap_w), .code_i(res_code_i), .lin_i(lin_mode_i), .word_o(snap_word)
    );

    angle_out_latch #(.OUT_W(OUT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .hold_n_i(hold_n_i), .busy_i(busy_o),
        .live_i(live_word), .snap_i(snap_word), .word_o(latched)
    );

    // R8 / R9: independently enabled bus groups
    assign data_o[OUT_W-1 -: HI_W] = en_hi_n_i ? {HI_W{1'bz}} : latched[OUT_W-1 -: HI_W];
    assign data_o[LO_W-1:0]        = en_lo_n_i ? {LO_W{1'bz}} : latched[LO_W-1:0];

endmodule

// File: tb/tb_angle_track_counter.sv
module tb_angle_track_counter;

    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0, dir_up = 1'b1, lin = 1'b0;
    logic [1:0]  code = 2'b10;
    logic        hold_n = 1'b1, en_hi_n = 1'b0, en_lo_n = 1'b0;
    wire  [13:0] bus;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    for (genvar i = 0; i < 14; i++) begin : g_pu
        pullup (bus[i]);
    end

    angle_track_counter #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .step_i(step), .dir_up_i(dir_up),
        .res_code_i(code), .lin_mode_i(lin), .hold_n_i(hold_n),
        .en_hi_n_i(en_hi_n), .en_lo_n_i(en_lo_n), .data_o(bus), .busy_o(busy)
    );

    typedef struct packed {
        logic [7:0]  n;
        logic        up;
        logic [1:0]  code;
        logic        lin;
        logic [13:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd1,  1'b0, 2'b00, 1'b0, 14'h3FF0},  // R1 wrap down to 65535, R3 10-bit
        '{8'd0,  1'b1, 2'b01, 1'b0, 14'h3FFC},  // R3 12-bit
        '{8'd0,  1'b1, 2'b10, 1'b0, 14'h3FFF},  // R3 14-bit
        '{8'd0,  1'b1, 2'b11, 1'b0, 14'h3FFF},  // R3 code 11
        '{8'd0,  1'b1, 2'b00, 1'b1, 14'h0FF0},  // R4 8-bit
        '{8'd0,  1'b1, 2'b01, 1'b1, 14'h0FFC},  // R4 10-bit, LSB at bit 2
        '{8'd0,  1'b1, 2'b10, 1'b1, 14'h0FFF},  // R4 12-bit
        '{8'd1,  1'b1, 2'b10, 1'b0, 14'h0000},  // R1 wrap up to 0
        '{8'd5,  1'b1, 2'b10, 1'b0, 14'h0001},  // R1 count 5
        '{8'd0,  1'b1, 2'b01, 1'b0, 14'h0000},  // R3 masks low bits
        '{8'd3,  1'b1, 2'b10, 1'b1, 14'h0002},  // R4 count 8
        '{8'd8,  1'b1, 2'b01, 1'b0, 14'h0004},  // R3 count 16
        '{8'd2,  1'b0, 2'b10, 1'b0, 14'h0003},  // R1 down to 14
        '{8'd40, 1'b1, 2'b01, 1'b1, 14'h000C}   // R4 count 54
    };

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic steps(input int n, input logic up);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            step   = 1'b1;
            dir_up = up;
        end
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic settle();
        repeat (BUSY + 4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset word", bus, 14'h0000);
        check("R11 reset busy", {13'd0, busy}, 14'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 word after release", bus, 14'h0000);

        // table walk: R1 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            if (VECS[v].n != 0) steps(int'(VECS[v].n), VECS[v].up);
            code = VECS[v].code;
            lin  = VECS[v].lin;
            settle();
            check($sformatf("R3/R4 vector %0d", v), bus, VECS[v].exp);
        end
        code = 2'b10;
        lin  = 1'b0;
        settle();  // count 54 -> word 13

        // R10: pulse width
        @(negedge clk); step = 1'b1; dir_up = 1'b1;
        @(negedge clk); step = 1'b0;
        check("R10 busy sample 1", {13'd0, busy}, 14'd1);
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            check($sformatf("R10 busy sample %0d", k), {13'd0, busy}, 14'd1);
        end
        @(negedge clk);
        check("R10 busy end", {13'd0, busy}, 14'd0);  // count 55

        // R10: restart
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 restarted pulse", {13'd0, busy}, 14'd1);
        @(negedge clk);
        @(negedge clk);
        check("R10 restarted end", {13'd0, busy}, 14'd0);
        settle();  // count 57 -> 14
        check("R5 word at 57", bus, 14'd14);

        // R6: freeze
        hold_n = 1'b0;
        @(negedge clk);
        steps(4, 1'b1);  // count 61 -> 15
        settle();
        check("R6 frozen", bus, 14'd14);
        hold_n = 1'b1;
        settle();
        check("R5 after release", bus, 14'd15);

        // R7: hold entered during busy
        steps(2, 1'b1);  // count 63
        settle();
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;   // count 64 -> 16
        @(negedge clk);
        check("R5 transparent one clock later", bus, 14'd16);
        hold_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 pre-step word held", bus, 14'd15);
        settle();
        check("R7 still held", bus, 14'd15);
        hold_n = 1'b1;
        settle();
        check("R5 release shows 16", bus, 14'd16);

        // R8 / R9: group enables (pull-ups read 1 when floating)
        en_hi_n = 1'b1;
        @(negedge clk);
        check("R8 upper group floats", {6'd0, bus[13:6]}, 14'h00FF);
        check("R9 lower group driven", {8'd0, bus[5:0]}, 14'h0010);
        en_hi_n = 1'b0;
        en_lo_n = 1'b1;
        @(negedge clk);
        check("R9 lower group floats", {8'd0, bus[5:0]}, 14'h003F);
        check("R8 upper group driven", {6'd0, bus[13:6]}, 14'h0000);
        en_lo_n = 1'b0;
        @(negedge clk);
        check("R8 R9 both driven", bus, 14'h0010);

        // R2: idle
        repeat (20) @(negedge clk);
        check("R2 idle word", bus, 14'h0010);
        check("R2 idle busy", {13'd0, busy}, 14'd0);

        // R11: reset again
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 second reset", bus, 14'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        steps(1, 1'b1);
        settle();
        check("R11 count restarts from 0", bus, 14'h0000);

        finish_run();
    end

endmodule